// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Port

This block is a synchronous serial port that moves 8-bit words over a four-wire SPI link, either as the clock-driving master or as a slave clocked by the far end. Software configures it through a single control word that carries an enable bit, the idle level of the serial clock and a 4-bit mode code. In master mode the serial clock comes from a divider on the system clock or from an external timer pulse. In slave mode the port follows an incoming clock, optionally gated by an active-low select input.

A word to send is written into the shift register. In master mode that write starts the transfer. Every received word is moved into a receive buffer and raises a buffer-full bit, which a buffer read clears. Two sticky status flags record misuse and stay set until software clears them. The collision flag records a write that arrives while a word is still shifting. The overflow flag records a slave word that arrives while the buffer is still unread.

Top module: `spi_port`

## Requirements
- R1: After reset the control word is all zero, buf_full, coll_flag and ovf_flag are 0, buf_rdata is 0, and sck_oe and sdo_oe are 0.
- R2: The control word is ctl_wdata[0]=enable, ctl_wdata[1]=clock idle level, ctl_wdata[5:2]=mode. Mode codes 0000, 0001 and 0010 are master modes whose SCK half-period is 2, 8 and 32 system clocks (SCK = clk/4, /16, /64). Mode code 0011 is a master mode in which SCK toggles once for each one-cycle pulse on tick_in.
- R3: In a master mode, buf_wr while no word is shifting starts a transfer of 16 SCK half-periods. SDO carries the word MSB first. SDO is valid before the first SCK edge and changes only on trailing edges, while SDI is sampled on leading edges. When the word ends, the received byte appears on buf_rdata with buf_full=1, and SCK rests at its idle level.
- R4: SCK idles at the level of ctl_wdata[1]. The leading edge is the transition away from that idle level, and the trailing edge is the return to it. This holds in both master and slave modes.
- R5: Mode codes 0100 and 0101 are slave modes clocked by sck_in. In mode 0101, ss_n is ignored: the port drives SDO and completes words with ss_n high.
- R6: In mode 0100, ss_n high turns SDO off (sdo_oe=0), blocks reception and discards a partly received word. The next selected word is received from its first bit.
- R7: buf_wr while a word is shifting sets coll_flag and leaves the word in progress unchanged. coll_flag stays 1 until a clr_coll pulse.
- R8: A slave word that completes while buf_full=1 sets ovf_flag and is lost: buf_rdata keeps the old byte. A master transfer never sets ovf_flag and overwrites the buffer. ovf_flag stays 1 until a clr_ovf pulse.
- R9: A buf_rd pulse clears buf_full.
- R10: With the enable bit 0, sck_oe and sdo_oe are 0, SCK does not toggle, and buf_wr neither starts a transfer nor sets coll_flag.
- R11: Mode codes 0110 to 1111 behave as disabled: both output enables are 0, and buf_wr has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: mode[5:2], idle level[1], enable[0] |
| buf_wr | input | 1 | Write of the next word to send |
| buf_wdata | input | 8 | Word to send |
| buf_rd | input | 1 | Receive buffer read strobe, clears buf_full |
| buf_rdata | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| clr_coll | input | 1 | Clears coll_flag |
| clr_ovf | input | 1 | Clears ovf_flag |
| coll_flag | output | 1 | Sticky write-collision flag |
| ovf_flag | output | 1 | Sticky slave receive-overflow flag |
| tick_in | input | 1 | External timer pulse, one cycle wide, used by mode 0011 |
| sck_in | input | 1 | Serial clock from the pin (slave modes) |
| sck_out | output | 1 | Serial clock driven in master modes |
| sck_oe | output | 1 | Output enable for sck_out |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| ss_n | input | 1 | Active-low slave select |

## Verification
The assertions assume three things about the inputs. tick_in pulses last one cycle. sck_in and ss_n change slowly enough that each level lasts several system clocks after the synchronizers. A flag set and its clear pulse never arrive in the same cycle. The bench keeps to these limits. It drives the slave clock with an 8-cycle half-period and spaces timer pulses 5 cycles apart. It changes sdi only on trailing edges. It issues clears and buffer reads only between words. Random bytes, polarities and modes are drawn under the same limits.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int unsigned BASE_HALF = 2;
  localparam int unsigned STEP_LOG2 = 2;
  localparam int unsigned CTL_W     = 6;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } role_e;

  typedef struct packed {
    logic [3:0] mode;
    logic       cpol;
    logic       en;
  } ctl_t;

  function automatic role_e mode_role(input logic [3:0] m);
    if (m[3:2] == 2'b00) return ROLE_MASTER;
    if (m == 4'b0100 || m == 4'b0101) return ROLE_SLAVE;
    return ROLE_OFF;
  endfunction

  function automatic logic mode_ss_used(input logic [3:0] m);
    return m == 4'b0100;
  endfunction

  function automatic logic mode_tick(input logic [3:0] m);
    return m == 4'b0011;
  endfunction

  // Half-period of SCK in system clocks for the divider modes
  function automatic int unsigned half_period(input logic [1:0] sel);
    return BASE_HALF << (STEP_LOG2 * sel);
  endfunction

endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             use_tick,
  input  logic             tick,
  input  logic [CNT_W-1:0] half_lim,
  output logic             half_pulse
);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_hit;

  assign cnt_hit    = (cnt_q == half_lim);
  assign half_pulse = run & (use_tick ? tick : cnt_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (!run || use_tick || cnt_hit) cnt_q <= '0;
    else                               cnt_q <= cnt_q + CNT_W'(1);
  end

  // R2: divided modes never produce two half-period events back to back
  a_r2_divided_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !use_tick && half_pulse && half_lim != '0) |=> !half_pulse);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              lead_ev,
  input  logic              trail_ev,
  input  logic              sdi_bit,
  output logic              sdo_bit,
  output logic              active,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              rx_bit_q;
  logic              half_q;

  assign sdo_bit = shreg_q[WORD_W-1];
  assign active  = half_q | (bit_cnt_q != '0);
  assign done    = trail_ev & half_q & (bit_cnt_q == LAST);
  assign rx_word = {shreg_q[WORD_W-2:0], rx_bit_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      bit_cnt_q <= '0;
      rx_bit_q  <= 1'b0;
      half_q    <= 1'b0;
    end else begin
      if (clear) begin
        bit_cnt_q <= '0;
        half_q    <= 1'b0;
      end else if (lead_ev && !half_q) begin
        rx_bit_q <= sdi_bit;
        half_q   <= 1'b1;
      end else if (trail_ev && half_q) begin
        shreg_q   <= {shreg_q[WORD_W-2:0], rx_bit_q};
        half_q    <= 1'b0;
        bit_cnt_q <= (bit_cnt_q == LAST) ? '0 : bit_cnt_q + CNT_W'(1);
      end
      if (load) shreg_q <= load_word;
    end
  end

  // R3: the word counter is back at its start after the final trailing edge
  a_r3_word_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (bit_cnt_q == '0 && !half_q));

endmodule

// File: rtl/spi_status.sv
module spi_status #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              is_slave,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rd,
  input  logic              coll_ev,
  input  logic              clr_coll,
  input  logic              clr_ovf,
  output logic [WORD_W-1:0] buf_q,
  output logic              full_q,
  output logic              coll_q,
  output logic              ovf_q
);

  logic ovf_ev;

  assign ovf_ev = done & is_slave & full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      coll_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (done && !ovf_ev) begin
        buf_q  <= rx_word;
        full_q <= 1'b1;
      end else if (rd) begin
        full_q <= 1'b0;
      end
      if (coll_ev)       coll_q <= 1'b1;
      else if (clr_coll) coll_q <= 1'b0;
      if (ovf_ev)        ovf_q <= 1'b1;
      else if (clr_ovf)  ovf_q <= 1'b0;
    end
  end

  // R8: overflow only arises from a slave word
  a_r8_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(is_slave));
  // R8: the lost word leaves the buffer untouched
  a_r8_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> $stable(buf_q));
  // R7: collision flag holds until cleared
  a_r7_coll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_q && !clr_coll) |=> coll_q);
  // R9: buffer-full only rises on a completed word
  a_r9_full_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(done));

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [5:0]        ctl_wdata,
  input  logic              buf_wr,
  input  logic [WORD_W-1:0] buf_wdata,
  input  logic              buf_rd,
  output logic [WORD_W-1:0] buf_rdata,
  output logic              buf_full,
  input  logic              clr_coll,
  input  logic              clr_ovf,
  output logic              coll_flag,
  output logic              ovf_flag,
  input  logic              tick_in,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              ss_n
);

  ctl_t  ctl_q;
  role_e role;
  logic  is_master, is_slave, uses_ss, uses_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_t'(ctl_wdata);
  end

  assign role      = mode_role(ctl_q.mode);
  assign is_master = ctl_q.en && (role == ROLE_MASTER);
  assign is_slave  = ctl_q.en && (role == ROLE_SLAVE);
  assign uses_ss   = mode_ss_used(ctl_q.mode);
  assign uses_tick = mode_tick(ctl_q.mode);

  // Pin synchronizers for the slave side
  logic [SYNC_STAGES-1:0] sck_sync_q, ss_sync_q;
  logic sck_prev_q, sck_s, ss_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync_q <= '0;
      ss_sync_q  <= '1;
      sck_prev_q <= 1'b0;
    end else begin
      sck_sync_q <= {sck_sync_q[SYNC_STAGES-2:0], sck_in};
      ss_sync_q  <= {ss_sync_q[SYNC_STAGES-2:0], ss_n};
      sck_prev_q <= sck_s;
    end
  end

  assign sck_s = sck_sync_q[SYNC_STAGES-1];
  assign ss_s  = ss_sync_q[SYNC_STAGES-1];

  logic slave_sel, s_edge, s_lead, s_trail;
  assign slave_sel = is_slave && (!uses_ss || !ss_s);
  assign s_edge    = sck_s ^ sck_prev_q;
  assign s_lead    = slave_sel & s_edge & (sck_s != ctl_q.cpol);
  assign s_trail   = slave_sel & s_edge & (sck_s == ctl_q.cpol);

  // Master side
  logic m_busy_q, sck_lvl_q, half_pulse, m_lead, m_trail;
  logic abort, busy, start, load, coll_ev;
  logic sh_active, sh_done, sh_sdo;
  logic [WORD_W-1:0] rx_word;
  logic [DIV_CNT_W-1:0] half_lim;

  assign abort   = ctl_wr | !(is_master | is_slave) | (is_slave & !slave_sel);
  assign busy    = is_master ? m_busy_q : sh_active;
  assign coll_ev = buf_wr & (is_master | is_slave) & busy;
  assign load    = buf_wr & (is_master | is_slave) & !busy & !ctl_wr;
  assign start   = load & is_master;
  assign m_lead  = is_master & m_busy_q & half_pulse & (sck_lvl_q == ctl_q.cpol);
  assign m_trail = is_master & m_busy_q & half_pulse & (sck_lvl_q != ctl_q.cpol);
  assign half_lim = DIV_CNT_W'(half_period(ctl_q.mode[1:0]) - 1);

  spi_clkgen #(.CNT_W(DIV_CNT_W)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (m_busy_q & is_master),
    .use_tick   (uses_tick),
    .tick       (tick_in),
    .half_lim   (half_lim),
    .half_pulse (half_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy_q  <= 1'b0;
      sck_lvl_q <= 1'b0;
    end else begin
      if (abort)        m_busy_q <= 1'b0;
      else if (start)   m_busy_q <= 1'b1;
      else if (sh_done) m_busy_q <= 1'b0;
      if (!m_busy_q || abort) sck_lvl_q <= ctl_q.cpol;
      else if (half_pulse)    sck_lvl_q <= ~sck_lvl_q;
    end
  end

  spi_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (abort),
    .load      (load),
    .load_word (buf_wdata),
    .lead_ev   (m_lead | s_lead),
    .trail_ev  (m_trail | s_trail),
    .sdi_bit   (sdi),
    .sdo_bit   (sh_sdo),
    .active    (sh_active),
    .done      (sh_done),
    .rx_word   (rx_word)
  );

  spi_status #(.WORD_W(WORD_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (sh_done),
    .is_slave (is_slave),
    .rx_word  (rx_word),
    .rd       (buf_rd),
    .coll_ev  (coll_ev),
    .clr_coll (clr_coll),
    .clr_ovf  (clr_ovf),
    .buf_q    (buf_rdata),
    .full_q   (buf_full),
    .coll_q   (coll_flag),
    .ovf_q    (ovf_flag)
  );

  assign sck_out = is_master ? sck_lvl_q : ctl_q.cpol;
  assign sck_oe  = is_master;
  assign sdo_oe  = is_master | slave_sel;
  assign sdo     = sh_sdo;

  // R10: a disabled port never has a master transfer running
  a_r10_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.en |=> !m_busy_q);
  // R6: a deselected slave drops any partial word
  a_r6_ss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slave && uses_ss && ss_s) |=> !sh_active);
  // R4: a finished master word leaves SCK at its idle level
  a_r4_master_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && is_master && !ctl_wr) |=> (sck_out == ctl_q.cpol));

endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;

  localparam int HP = 8;
  localparam int TICK_GAP = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, buf_wr = 0, buf_rd = 0, clr_coll = 0, clr_ovf = 0;
  logic [5:0] ctl_wdata = '0;
  logic [7:0] buf_wdata = '0, buf_rdata;
  logic buf_full, coll_flag, ovf_flag, sck_out, sck_oe, sdo, sdo_oe;
  logic tick_in = 0, sck_in = 0, sdi = 0, ss_n = 1;
  bit   tick_run = 0;
  int   checks = 0, errors = 0;

  spi_port dut (.*);

  always #5 clk = ~clk;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
    $finish;
  end

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      if (tick_run && tc == TICK_GAP - 1) begin tick_in = 1; tc = 0; end
      else begin tick_in = 0; if (tick_run) tc++; else tc = 0; end
    end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic ctl_set(input bit en, input bit cpol, input logic [3:0] mode);
    ctl_wr = 1; ctl_wdata = {mode, cpol, en}; cyc(1); ctl_wr = 0;
  endtask

  task automatic wr_word(input logic [7:0] d);
    buf_wr = 1; buf_wdata = d; cyc(1); buf_wr = 0;
  endtask

  task automatic rd_buf(); buf_rd = 1; cyc(1); buf_rd = 0; endtask

  // Expected SCK half-period in system clocks for the divider modes (R2)
  function automatic int exp_half(input int mode);
    if (mode == 0) return 2;
    if (mode == 1) return 8;
    return 32;
  endfunction

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sl, input int half,
                             input bit cpol, input bit do_coll,
                             output logic [7:0] seen, output bit gap_ok);
    int toggles = 0, tr = 0, since = 0;
    logic last;
    seen = '0; gap_ok = 1;
    sdi = sl[7];
    buf_wr = 1; buf_wdata = tx; cyc(1); buf_wr = 0;
    last = sck_out;
    check(last == cpol, "R4 idle level before word", last, cpol);
    while (toggles < 16) begin
      cyc(1); since++;
      if (do_coll && toggles == 5 && since == 1) begin buf_wr = 1; buf_wdata = ~tx; end
      else buf_wr = 0;
      if (sck_out != last) begin
        toggles++;
        if (toggles > 1 && since != half) gap_ok = 0;
        since = 0; last = sck_out;
        if (sck_out != cpol) seen[7 - (toggles - 1) / 2] = sdo;
        else begin tr++; if (tr < 8) sdi = sl[7 - tr]; end
      end
    end
    buf_wr = 0;
  endtask

  task automatic slave_xfer(input logic [7:0] to_dut, input int nbits, input bit cpol,
                            output logic [7:0] from_dut);
    from_dut = '0;
    sck_in = cpol;
    for (int i = 0; i < nbits; i++) begin
      sdi = to_dut[7 - i];
      cyc(HP);
      from_dut[7 - i] = sdo;
      sck_in = ~cpol;
      cyc(HP);
      sck_in = cpol;
    end
    cyc(HP);
  endtask

  task automatic run_master(input int mode, input bit cpol, input logic [7:0] tx,
                            input logic [7:0] sl, input string tag);
    logic [7:0] seen; bit gok;
    ctl_set(1, cpol, mode[3:0]);
    master_xfer(tx, sl, (mode == 3) ? TICK_GAP : exp_half(mode), cpol, 0, seen, gok);
    check(gok, {tag, " R2 half-period"}, gok, 1);
    check(seen == tx, {tag, " R3 sdo word"}, seen, tx);
    check(buf_rdata == sl && buf_full, {tag, " R3 rx word"}, buf_rdata, sl);
    check(sck_out == cpol, {tag, " R4 rest level"}, sck_out, cpol);
  endtask

  task automatic run_slave(input bit cpol, input logic [7:0] tx, input logic [7:0] rx,
                           input string tag);
    logic [7:0] got;
    sck_in = cpol;
    ctl_set(1, cpol, 4'b0101);
    cyc(4);
    wr_word(tx);
    slave_xfer(rx, 8, cpol, got);
    check(got == tx, {tag, " R5 slave sdo"}, got, tx);
    check(buf_rdata == rx && buf_full, {tag, " R5 slave rx"}, buf_rdata, rx);
  endtask

  initial begin
    logic [7:0] seen, got;
    bit gok;
    void'($urandom(32'd4242));
    cyc(3); rst_n = 1; cyc(2);

    // R1 reset state
    check(!buf_full && !coll_flag && !ovf_flag, "R1 flags", {buf_full, coll_flag, ovf_flag}, 0);
    check(!sck_oe && !sdo_oe, "R1 pins", {sck_oe, sdo_oe}, 0);
    check(buf_rdata == 0, "R1 buffer", buf_rdata, 0);

    // R10 disabled port ignores writes
    begin
      int tg = 0; logic l;
      ctl_set(0, 0, 4'b0000);
      wr_word(8'hA5);
      l = sck_out;
      for (int i = 0; i < 40; i++) begin cyc(1); if (sck_out != l) tg++; l = sck_out; end
      check(tg == 0, "R10 no sck activity", tg, 0);
      check(!coll_flag && !buf_full && !sck_oe && !sdo_oe, "R10 ignored write",
            {coll_flag, buf_full, sck_oe, sdo_oe}, 0);
    end

    // R2/R3 master divider modes, directed
    run_master(0, 0, 8'hA5, 8'h3C, "m0");
    run_master(1, 0, 8'h81, 8'h7E, "m1");
    check(!ovf_flag, "R8 master never overflows", ovf_flag, 0);
    check(buf_rdata == 8'h7E, "R8 master overwrites", buf_rdata, 8'h7E);
    rd_buf();
    check(!buf_full, "R9 read clears full", buf_full, 0);
    run_master(2, 0, 8'h5A, 8'hC3, "m2");
    rd_buf();

    // R2 timer-driven master
    tick_run = 1;
    run_master(3, 0, 8'h96, 8'h69, "m3");
    tick_run = 0;
    rd_buf();

    // R4 idle-high clock
    run_master(0, 1, 8'h0F, 8'hF0, "cpol1");
    rd_buf();

    // R7 collision
    ctl_set(1, 0, 4'b0000);
    master_xfer(8'hB4, 8'h2D, 2, 0, 1, seen, gok);
    check(coll_flag, "R7 collision set", coll_flag, 1);
    check(seen == 8'hB4, "R7 word in progress kept", seen, 8'hB4);
    check(buf_rdata == 8'h2D, "R7 rx unaffected", buf_rdata, 8'h2D);
    cyc(10);
    check(coll_flag, "R7 sticky", coll_flag, 1);
    clr_coll = 1; cyc(1); clr_coll = 0;
    check(!coll_flag, "R7 cleared", coll_flag, 0);
    rd_buf();

    // R5 slave without select, ss_n high
    ss_n = 1;
    run_slave(0, 8'h3C, 8'h96, "s5");
    check(sdo_oe && !sck_oe, "R5 slave drives sdo only", {sdo_oe, sck_oe}, 2);
    // R8 overflow: second word while full
    wr_word(8'h00);
    slave_xfer(8'h11, 8, 0, got);
    check(ovf_flag, "R8 overflow set", ovf_flag, 1);
    check(buf_rdata == 8'h96, "R8 old byte kept", buf_rdata, 8'h96);
    clr_ovf = 1; cyc(1); clr_ovf = 0;
    check(!ovf_flag, "R8 cleared", ovf_flag, 0);
    rd_buf();

    // R6 select-gated slave, idle-high clock
    sck_in = 1;
    ctl_set(1, 1, 4'b0100);
    cyc(4);
    check(!sdo_oe, "R6 deselected sdo off", sdo_oe, 0);
    slave_xfer(8'hE7, 8, 1, got);
    check(!buf_full, "R6 deselected no rx", buf_full, 0);
    ss_n = 0; cyc(4);
    check(sdo_oe, "R6 selected sdo on", sdo_oe, 1);
    slave_xfer(8'hFF, 4, 1, got);
    ss_n = 1; cyc(6);
    ss_n = 0; cyc(4);
    wr_word(8'hC3);
    slave_xfer(8'h5A, 8, 1, got);
    check(buf_rdata == 8'h5A && buf_full, "R6 fresh word after deselect", buf_rdata, 8'h5A);
    check(got == 8'hC3, "R4 R6 slave sdo idle-high", got, 8'hC3);
    ss_n = 1;
    rd_buf();

    // R11 unassigned mode code
    ctl_set(1, 0, 4'b0110);
    wr_word(8'h55);
    cyc(20);
    check(!sck_oe && !sdo_oe && !coll_flag && !buf_full, "R11 unassigned mode inert",
          {sck_oe, sdo_oe, coll_flag, buf_full}, 0);

    // Random mix
    for (int k = 0; k < 16; k++) begin
      int sel = $urandom % 4;
      bit cp = 1'($urandom % 2);
      logic [7:0] a = 8'($urandom), b = 8'($urandom);
      if (sel < 3) run_master(sel, cp, a, b, "rnd master");
      else run_slave(cp, a, b, "rnd slave");
      rd_buf();
      check(!buf_full && !ovf_flag && !coll_flag, "R9 rnd clean",
            {buf_full, ovf_flag, coll_flag}, 0);
    end

    summary();
    $finish;
  end

endmodule